// File: doc/BRIEF.md
# Fetch Next-PC Predictor

This block guesses where instruction fetch goes next. The fetch stage presents its current program counter and, in the same cycle, receives a predicted next address. Two tables are used for the guess. One holds a 2-bit saturating confidence counter for each direction slot. The other holds the most recent taken target for recently seen branches. The fetch is redirected to a stored target only when the counter's upper bit calls the branch taken and the target table holds a matching entry. In every other case the prediction is the sequential address, PC+4.

Training arrives from the resolve stage on a single update port. The port carries a branch address, whether the branch was really taken, and where it really went. The counter that the address selects moves one step toward the outcome, and it saturates at both ends. A branch that resolves taken writes its target, its tag and a valid flag into the target-table slot its address selects. That write replaces whatever the slot held before. Updates take effect at the next clock edge.

Top module: `bpred_top`

## Requirements
- R1: A taken update adds one to the selected counter, and a counter at 2'b11 stays at 2'b11.
- R2: A not-taken update subtracts one from the selected counter, and a counter at 2'b00 stays at 2'b00.
- R3: When bit 1 of the counter selected by the fetch address is 0, the next PC is fetch_pc+4.
- R4: When the counter's bit 1 is 1 and the target table hits, the next PC is the stored target. A hit means the selected slot is valid and its stored tag equals fetch_pc[31:6].
- R5: When the counter's bit 1 is 1 and the target table misses, the next PC is fetch_pc+4.
- R6: After reset every counter holds 2'b01 and every target slot is invalid, so every fetch address predicts fetch_pc+4.
- R7: A taken update writes the target, the tag upd_pc[31:6] and the valid flag into slot upd_pc[5:2]. A not-taken update leaves the target table unchanged.
- R8: An update becomes visible to lookups from the clock edge that ends its cycle. A lookup in the same cycle as an update sees the old contents.
- R9: Counters are selected by pc[7:2] and target slots by pc[5:2]. Two addresses that share a slot but differ in tag do not hit on each other's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_next_pc | output | 32 | Predicted next fetch address, combinational from fetch_pc |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |

## Verification
The bench builds the block with its default sizes: 64 counters, 16 target slots and a 32-bit address. With these sizes, addresses such as 0x204 and 0x304 share a counter and a target slot but carry different tags. That pairing makes aliasing and tag misses easy to stage. The random phase draws from a small set of addresses, so counters reach both saturation limits and slots are replaced many times. Every cycle is compared against a behavioural model.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_INIT = 2'b01;

  // Move one step toward the actual outcome, saturating at both ends.
  function automatic ctr2_t ctr_train(input ctr2_t c, input logic taken);
    ctr2_t r;
    if (taken) r = (c == 2'b11) ? c : c + 2'd1;
    else       r = (c == 2'b00) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_taken(input ctr2_t c);
    return c[1];
  endfunction

  function automatic logic [31:0] pc_seq(input logic [31:0] pc);
    return pc + 32'd4;
  endfunction
endpackage

// File: rtl/bpred_dir_table.sv
module bpred_dir_table
  import bpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_taken,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken,
  output ctr2_t           wr_cnt_now
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t            cnt [DEPTH];
  logic [IDX_W-1:0] rd_idx, wr_idx;

  assign rd_idx     = rd_pc[IDX_W+1:2];
  assign wr_idx     = wr_pc[IDX_W+1:2];
  assign rd_taken   = ctr_taken(cnt[rd_idx]);
  assign wr_cnt_now = cnt[wr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= CTR_INIT;
    end else if (wr_en) begin
      cnt[wr_idx] <= ctr_train(cnt[wr_idx], wr_taken);
    end
  end
endmodule

// File: rtl/bpred_target_buf.sv
module bpred_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_target,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - 2 - IDX_W;

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag [DEPTH];
  logic [PC_W-1:0]  tgt [DEPTH];
  logic [IDX_W-1:0] rd_idx, wr_idx;

  assign rd_idx    = rd_pc[IDX_W+1:2];
  assign wr_idx    = wr_pc[IDX_W+1:2];
  assign rd_hit    = vld[rd_idx] && (tag[rd_idx] == rd_pc[PC_W-1:IDX_W+2]);
  assign rd_target = tgt[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  // Payload needs no reset: it is only read through a set valid flag.
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && wr_idx == IDX_W'(g)) begin
          tag[g] <= wr_pc[PC_W-1:IDX_W+2];
          tgt[g] <= wr_target;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bpred_next_pc.sv
module bpred_next_pc
  import bpred_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic            dir_taken,
  input  logic            tb_hit,
  input  logic [PC_W-1:0] tb_target,
  output logic            redirect,
  output logic [PC_W-1:0] next_pc
);
  assign redirect = dir_taken && tb_hit;
  assign next_pc  = redirect ? tb_target : PC_W'(pc_seq(32'(pc)));
endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int DIR_IDX_W = 6,
  parameter int TB_IDX_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  // Named internal events, observed by the bound checker.
  logic            dir_taken;
  logic            tb_hit;
  logic [PC_W-1:0] tb_target;
  logic            redirect;
  ctr2_t           upd_cnt_now;
  logic            tb_write;

  assign tb_write = upd_valid && upd_taken;

  bpred_dir_table #(.PC_W(PC_W), .IDX_W(DIR_IDX_W)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(fetch_pc), .rd_taken(dir_taken),
    .wr_en(upd_valid), .wr_pc(upd_pc), .wr_taken(upd_taken),
    .wr_cnt_now(upd_cnt_now)
  );

  bpred_target_buf #(.PC_W(PC_W), .IDX_W(TB_IDX_W)) u_tb (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(fetch_pc), .rd_hit(tb_hit), .rd_target(tb_target),
    .wr_en(tb_write), .wr_pc(upd_pc), .wr_target(upd_target)
  );

  bpred_next_pc #(.PC_W(PC_W)) u_mux (
    .pc(fetch_pc), .dir_taken(dir_taken), .tb_hit(tb_hit),
    .tb_target(tb_target), .redirect(redirect), .next_pc(pred_next_pc)
  );
endmodule

// File: rtl/bpred_top_chk.sv
module bpred_top_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target,
  input logic            dir_taken,
  input logic            tb_hit,
  input logic [PC_W-1:0] tb_target,
  input logic [1:0]      upd_cnt_now
);
  // R3
  seq_when_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_taken |-> pred_next_pc == fetch_pc + PC_W'(4));

  // R4
  target_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_taken && tb_hit) |-> pred_next_pc == tb_target);

  // R5
  seq_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_taken && !tb_hit) |-> pred_next_pc == fetch_pc + PC_W'(4));

  // R1
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      (upd_pc != $past(upd_pc)) ||
      (upd_cnt_now == (($past(upd_cnt_now) == 2'b11) ? 2'b11 : $past(upd_cnt_now) + 2'd1)));

  // R2
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=>
      (upd_pc != $past(upd_pc)) ||
      (upd_cnt_now == (($past(upd_cnt_now) == 2'b00) ? 2'b00 : $past(upd_cnt_now) - 2'd1)));

  // R7
  alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      (fetch_pc != $past(upd_pc)) || (tb_hit && tb_target == $past(upd_target)));
endmodule

bind bpred_top bpred_top_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
  .upd_target(upd_target), .dir_taken(dir_taken), .tb_hit(tb_hit),
  .tb_target(tb_target), .upd_cnt_now(upd_cnt_now)
);

// File: tb/tb_bpred_top.sv
`timescale 1ns/1ps
module tb_bpred_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] pred_next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  bpred_top dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target)
  );

  // Behavioural reference: plain integers and bit vectors.
  int          m_cnt [64];
  bit          m_vld [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];

  function automatic logic [31:0] model_next(input logic [31:0] pc);
    int d = int'(pc[7:2]);
    int s = int'(pc[5:2]);
    if (m_cnt[d] >= 2 && m_vld[s] && m_tag[s] == pc[31:6]) return m_tgt[s];
    return pc + 32'd4;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_cnt[i] = 1;
    for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
  endtask

  task automatic model_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    int d = int'(pc[7:2]);
    int s = int'(pc[5:2]);
    if (tk) begin
      if (m_cnt[d] < 3) m_cnt[d]++;
      m_vld[s] = 1'b1; m_tag[s] = pc[31:6]; m_tgt[s] = tg;
    end else if (m_cnt[d] > 0) m_cnt[d]--;
  endtask

  // One cycle: drive after the falling edge, compare, then let the edge commit.
  task automatic step(input string req, input logic [31:0] pc,
                      input logic uv, input logic [31:0] upc,
                      input logic ut, input logic [31:0] utg);
    logic [31:0] exp;
    @(negedge clk);
    fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    exp = model_next(pc);  // old contents (R8)
    checks++;
    if (pred_next_pc !== exp) begin
      errors++;
      $display("FAIL %s pc=%h actual=%h expected=%h", req, pc, pred_next_pc, exp);
    end
    @(posedge clk);
    if (uv) model_update(upc, ut, utg);
  endtask

  task automatic look(input string req, input logic [31:0] pc);
    step(req, pc, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic train(input string req, input logic [31:0] bpc, input logic tk, input logic [31:0] tg);
    step(req, 32'h0000_0f00, 1'b1, bpc, tk, tg);
  endtask

  bit done = 1'b0;

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6: reset state, every address sequential
    look("R6", 32'h0000_0100);
    look("R6", 32'h0000_0204);
    look("R6", 32'hffff_fffc);

    // R1, R4, R7: one taken update lifts 01 to 10 and allocates
    train("R1", 32'h0000_0100, 1'b1, 32'h0000_4000);
    look("R4", 32'h0000_0100);
    look("R7", 32'h0000_0100);

    // R1 saturation: three more taken, one not-taken must still predict taken
    train("R1", 32'h0000_0100, 1'b1, 32'h0000_4000);
    train("R1", 32'h0000_0100, 1'b1, 32'h0000_4000);
    train("R1", 32'h0000_0100, 1'b1, 32'h0000_4000);
    train("R2", 32'h0000_0100, 1'b0, 32'h0);
    look("R1", 32'h0000_0100);
    // R7: the not-taken update left the stored target in place
    look("R7", 32'h0000_0100);

    // R2, R3: drop to 00 and saturate there; one taken gives 01, still sequential
    repeat (4) train("R2", 32'h0000_0100, 1'b0, 32'h0);
    look("R3", 32'h0000_0100);
    train("R2", 32'h0000_0100, 1'b1, 32'h0000_5000);
    look("R2", 32'h0000_0100);
    look("R3", 32'h0000_0100);

    // R5, R9: 0x204 and 0x304 share a counter and a slot, tags differ
    train("R9", 32'h0000_0204, 1'b1, 32'h0000_6000);
    train("R9", 32'h0000_0204, 1'b1, 32'h0000_6000);
    look("R4", 32'h0000_0204);
    look("R5", 32'h0000_0304);
    // R9: aliasing update replaces the slot
    train("R9", 32'h0000_0304, 1'b1, 32'h0000_7000);
    look("R9", 32'h0000_0304);
    look("R9", 32'h0000_0204);

    // R8: update and lookup of the same address in one cycle see old contents
    step("R8", 32'h0000_0204, 1'b1, 32'h0000_0204, 1'b1, 32'h0000_8000);
    look("R8", 32'h0000_0204);
    step("R8", 32'h0000_0204, 1'b1, 32'h0000_0204, 1'b0, 32'h0);
    look("R8", 32'h0000_0204);

    // Mixed stream over a small address set (R1..R9)
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      a = {22'(($urandom % 4) * 3), 10'(($urandom % 12) * 4)};
      b = {22'(($urandom % 4) * 3), 10'(($urandom % 12) * 4)};
      step("R9", a, 1'($urandom % 2), b, 1'($urandom % 3 != 0), $urandom & 32'hffff_fffc);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule